// File: doc/BRIEF.md
# SoC Power Mode Controller

This block steps a chip through four power modes: normal, idle, slow and sleep. It runs from an always-on clock. It drives registered clock enables for the CPU core, the always-on basic blocks and a set of peripherals that software can gate one by one. It also drives the enable for the external regulator that powers the core. Software changes the mode by writing a control word. Interrupt lines and an RTC alarm bring the chip back to normal mode.

Only some mode changes are legal. Normal mode can go to idle, slow or sleep. Slow mode can only go back to normal. Idle and sleep can only leave through a wake event, and that event always leads to normal. A request for any other change is dropped. Idle stops only the core clock. Sleep stops every clock and turns the core supply off. The two modes also accept different wake sources.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` = 0 (normal), the core, basic and power enables are 1, `slow_clk_sel` is 0, `periph_clk_en` equals the parameter `PERIPH_RST` (all ones by default) and external-line waking is off.
- R2: In normal mode, a write of `ctrl_wdata` stores bits [4 +: N_PERIPH] as the peripheral enables and bit 3 as the external-line wake enable. It then picks the next mode by priority: bit 1 (sleep) first, then bit 0 (idle), then bit 2 (slow). If none of these is set, the mode stays normal. The new outputs appear at the same clock edge that takes the write.
- R3: In slow mode, a write stores the peripheral enables and the wake enable. The mode returns to normal only when bit 2 is 0. Idle and sleep bits written in slow mode are ignored.
- R4: While in idle or sleep, every write is ignored. The mode, the peripheral enables and the wake enable all stay unchanged.
- R5: In idle mode, `core_clk_en` is 0, while `basic_clk_en` and `core_pwr_en` are 1 and `periph_clk_en` keeps the stored enables.
- R6: Idle mode returns to normal at the edge that samples any qualified external line, `rtc_alarm` or `other_irq` high.
- R7: External lines wake the block only while the wake enable (control bit 3) is 1. When it is 0 they are ignored in idle and in sleep.
- R8: In sleep mode, `core_clk_en`, `basic_clk_en`, `core_pwr_en` and every `periph_clk_en` bit are 0.
- R9: Sleep mode returns to normal only on `rtc_alarm` or on a qualified external line below index `N_SLEEP_WAKE` (16). `other_irq` and the higher lines do not wake it.
- R10: `mode_o` is encoded as 0 = normal, 1 = idle, 2 = slow, 3 = sleep. `slow_clk_sel` is 1 only in slow mode. The core clock runs in slow mode.
- R11: After a wake, the peripheral enables and the wake enable hold the values they had before idle or sleep was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4+N_PERIPH | Control word: [0] idle, [1] sleep, [2] slow, [3] external wake enable, [4 +: N_PERIPH] peripheral enables |
| ext_irq | input | N_EXT | External interrupt lines |
| rtc_alarm | input | 1 | RTC alarm interrupt |
| other_irq | input | 1 | Other internal interrupt requests |
| mode_o | output | 2 | Current power mode |
| core_clk_en | output | 1 | CPU core clock enable |
| basic_clk_en | output | 1 | Always-on basic block clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| core_pwr_en | output | 1 | External regulator enable for the core supplies |
| slow_clk_sel | output | 1 | Selects the slow clock source |

## Verification
The bench writes idle and sleep requests while the block is in slow mode, and writes control words while it is in idle or sleep. A design that did not restrict transitions would wrongly leave slow for idle or sleep, or would pick up new peripheral enables while halted. The bench also drives `other_irq` and a high-numbered external line during sleep, which catches a design that treats the idle and sleep wake sets as one. It pulses external lines while the wake enable is off, so a design that skips that gate would wake early. Finally, it sets the sleep and idle bits in the same write to check the priority order.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_IDLE   = 2'd1,
        PM_SLOW   = 2'd2,
        PM_SLEEP  = 2'd3
    } pm_mode_e;

    localparam int CB_IDLE   = 0;
    localparam int CB_SLEEP  = 1;
    localparam int CB_SLOW   = 2;
    localparam int CB_WAKEEN = 3;
    localparam int CB_PERIPH = 4;
endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
    parameter int N_EXT        = 24,
    parameter int N_SLEEP_WAKE = 16
) (
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             ext_wake_en,
    input  logic             rtc_alarm,
    input  logic             other_irq,
    output logic             idle_wake,
    output logic             sleep_wake
);
    logic [N_EXT-1:0] ext_qual;

    always_comb begin
        ext_qual   = ext_irq & {N_EXT{ext_wake_en}};
        idle_wake  = (|ext_qual) | rtc_alarm | other_irq;
        sleep_wake = (|ext_qual[N_SLEEP_WAKE-1:0]) | rtc_alarm;
    end
endmodule

// File: rtl/pmc_out_reg.sv
module pmc_out_reg
    import pmc_pkg::*;
#(
    parameter int                    N_PERIPH   = 8,
    parameter logic [N_PERIPH-1:0]   PERIPH_RST = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pm_mode_e            mode_d,
    input  logic [N_PERIPH-1:0] periph_d,
    output logic                core_clk_en,
    output logic                basic_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                core_pwr_en,
    output logic                slow_clk_sel
);
    typedef struct packed {
        logic                core;
        logic                basic;
        logic [N_PERIPH-1:0] periph;
        logic                pwr;
        logic                slow;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.core   = (mode_d == PM_NORMAL) || (mode_d == PM_SLOW);
        o_d.basic  = (mode_d != PM_SLEEP);
        o_d.pwr    = (mode_d != PM_SLEEP);
        o_d.slow   = (mode_d == PM_SLOW);
        o_d.periph = (mode_d == PM_SLEEP) ? '0 : periph_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.core   <= 1'b1;
            o_q.basic  <= 1'b1;
            o_q.periph <= PERIPH_RST;
            o_q.pwr    <= 1'b1;
            o_q.slow   <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign core_clk_en   = o_q.core;
    assign basic_clk_en  = o_q.basic;
    assign periph_clk_en = o_q.periph;
    assign core_pwr_en   = o_q.pwr;
    assign slow_clk_sel  = o_q.slow;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int                  N_EXT        = 24,
    parameter int                  N_SLEEP_WAKE = 16,
    parameter int                  N_PERIPH     = 8,
    parameter logic [N_PERIPH-1:0] PERIPH_RST   = '1,
    localparam int                 CTRL_W       = CB_PERIPH + N_PERIPH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic                rtc_alarm,
    input  logic                other_irq,
    output logic [1:0]          mode_o,
    output logic                core_clk_en,
    output logic                basic_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                core_pwr_en,
    output logic                slow_clk_sel
);
    typedef struct packed {
        pm_mode_e            mode;
        logic [N_PERIPH-1:0] periph;
        logic                wake_en;
    } st_t;

    st_t  st_d, st_q;
    logic idle_wake, sleep_wake;

    pmc_wake_qual #(
        .N_EXT        (N_EXT),
        .N_SLEEP_WAKE (N_SLEEP_WAKE)
    ) u_wake (
        .ext_irq     (ext_irq),
        .ext_wake_en (st_q.wake_en),
        .rtc_alarm   (rtc_alarm),
        .other_irq   (other_irq),
        .idle_wake   (idle_wake),
        .sleep_wake  (sleep_wake)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_NORMAL: begin
                if (ctrl_wr) begin
                    st_d.periph  = ctrl_wdata[CB_PERIPH +: N_PERIPH];
                    st_d.wake_en = ctrl_wdata[CB_WAKEEN];
                    if (ctrl_wdata[CB_SLEEP])      st_d.mode = PM_SLEEP;
                    else if (ctrl_wdata[CB_IDLE])  st_d.mode = PM_IDLE;
                    else if (ctrl_wdata[CB_SLOW])  st_d.mode = PM_SLOW;
                end
            end
            PM_SLOW: begin
                if (ctrl_wr) begin
                    st_d.periph  = ctrl_wdata[CB_PERIPH +: N_PERIPH];
                    st_d.wake_en = ctrl_wdata[CB_WAKEEN];
                    if (!ctrl_wdata[CB_SLOW]) st_d.mode = PM_NORMAL;
                end
            end
            PM_IDLE: begin
                if (idle_wake) st_d.mode = PM_NORMAL;
            end
            PM_SLEEP: begin
                if (sleep_wake) st_d.mode = PM_NORMAL;
            end
            default: st_d.mode = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= PM_NORMAL;
            st_q.periph  <= PERIPH_RST;
            st_q.wake_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pmc_out_reg #(
        .N_PERIPH   (N_PERIPH),
        .PERIPH_RST (PERIPH_RST)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_d        (st_d.mode),
        .periph_d      (st_d.periph),
        .core_clk_en   (core_clk_en),
        .basic_clk_en  (basic_clk_en),
        .periph_clk_en (periph_clk_en),
        .core_pwr_en   (core_pwr_en),
        .slow_clk_sel  (slow_clk_sel)
    );

    assign mode_o = st_q.mode;

    assert_sleep_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_SLEEP) |-> (!core_pwr_en && !basic_clk_en && !core_clk_en && periph_clk_en == '0));

    assert_idle_core_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_IDLE) |-> (!core_clk_en && basic_clk_en && core_pwr_en));

    assert_slow_exit_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_SLOW) |=> (st_q.mode == PM_SLOW || st_q.mode == PM_NORMAL));

    assert_halted_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == PM_IDLE && !idle_wake) || (st_q.mode == PM_SLEEP && !sleep_wake))
        |=> ($stable(st_q) && $stable(periph_clk_en)));

    assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_IDLE && idle_wake) |=> (st_q.mode == PM_NORMAL && core_clk_en));

    assert_sleep_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_SLEEP && sleep_wake) |=> (st_q.mode == PM_NORMAL && core_pwr_en));

    assert_slow_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slow_clk_sel == (st_q.mode == PM_SLOW));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int N_EXT = 24;
    localparam int N_PERIPH = 8;
    localparam int CTRL_W = 4 + N_PERIPH;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ctrl_wr = 1'b0;
    logic [CTRL_W-1:0]   ctrl_wdata = '0;
    logic [N_EXT-1:0]    ext_irq = '0;
    logic                rtc_alarm = 1'b0;
    logic                other_irq = 1'b0;
    logic [1:0]          mode_o;
    logic                core_clk_en, basic_clk_en, core_pwr_en, slow_clk_sel;
    logic [N_PERIPH-1:0] periph_clk_en;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;
    string tag = "R1";

    int              m_mode = 0;
    logic [7:0]      m_periph = 8'hFF;
    logic            m_wake_en = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ext_irq(ext_irq), .rtc_alarm(rtc_alarm), .other_irq(other_irq),
        .mode_o(mode_o), .core_clk_en(core_clk_en), .basic_clk_en(basic_clk_en),
        .periph_clk_en(periph_clk_en), .core_pwr_en(core_pwr_en),
        .slow_clk_sel(slow_clk_sel)
    );

    // Reference model, updated from the inputs present at each rising edge
    always @(posedge clk) begin
        logic wi, ws;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_periph = 8'hFF; m_wake_en = 1'b0;
        end else begin
            wi = (m_wake_en && ext_irq != 0) || rtc_alarm || other_irq;
            ws = (m_wake_en && ext_irq[15:0] != 0) || rtc_alarm;
            case (m_mode)
                0: if (ctrl_wr) begin
                       m_periph = ctrl_wdata[11:4];
                       m_wake_en = ctrl_wdata[3];
                       if (ctrl_wdata[1]) m_mode = 3;
                       else if (ctrl_wdata[0]) m_mode = 1;
                       else if (ctrl_wdata[2]) m_mode = 2;
                   end
                2: if (ctrl_wr) begin
                       m_periph = ctrl_wdata[11:4];
                       m_wake_en = ctrl_wdata[3];
                       if (!ctrl_wdata[2]) m_mode = 0;
                   end
                1: if (wi) m_mode = 0;
                default: if (ws) m_mode = 0;
            endcase
        end
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [1:0] e_mode;
        logic e_core, e_basic, e_pwr, e_slow;
        logic [7:0] e_per;
        if (rst_n) begin
            e_mode  = 2'(m_mode);
            e_core  = (m_mode == 0) || (m_mode == 2);
            e_basic = (m_mode != 3);
            e_pwr   = (m_mode != 3);
            e_slow  = (m_mode == 2);
            e_per   = (m_mode == 3) ? 8'h00 : m_periph;
            n_checks++;
            if (mode_o !== e_mode || core_clk_en !== e_core || basic_clk_en !== e_basic ||
                core_pwr_en !== e_pwr || slow_clk_sel !== e_slow || periph_clk_en !== e_per) begin
                n_fails++;
                $display("FAIL %s: actual mode=%0d core=%b basic=%b pwr=%b slow=%b per=%h expected mode=%0d core=%b basic=%b pwr=%b slow=%b per=%h",
                         tag, mode_o, core_clk_en, basic_clk_en, core_pwr_en, slow_clk_sel, periph_clk_en,
                         e_mode, e_core, e_basic, e_pwr, e_slow, e_per);
            end
        end
    end

    function automatic logic [CTRL_W-1:0] cw(logic [7:0] per, logic wen, logic slow, logic slp, logic idl);
        return {per, wen, slow, slp, idl};
    endfunction

    task automatic wr(input logic [CTRL_W-1:0] d);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input logic [N_EXT-1:0] e, input logic rtc, input logic oth);
        @(negedge clk);
        ext_irq = e; rtc_alarm = rtc; other_irq = oth;
        @(negedge clk);
        ext_irq = '0; rtc_alarm = 1'b0; other_irq = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; repeat (3) @(negedge clk);

        tag = "R2"; wr(cw(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0));
        tag = "R10"; wr(cw(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0));
        tag = "R3"; wr(cw(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1));
        tag = "R3"; wr(cw(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0));

        tag = "R5"; wr(cw(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1));
        tag = "R7"; pulse(24'h000008, 1'b0, 1'b0);
        tag = "R6"; pulse('0, 1'b0, 1'b1);

        tag = "R2"; wr(cw(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1));
        tag = "R4"; wr(cw(8'h00, 1'b0, 1'b0, 1'b1, 1'b0));
        tag = "R6"; pulse(24'h100000, 1'b0, 1'b0);
        tag = "R11"; repeat (2) @(negedge clk);

        tag = "R8"; wr(cw(8'h99, 1'b1, 1'b0, 1'b1, 1'b0));
        tag = "R9"; pulse('0, 1'b0, 1'b1);
        tag = "R9"; pulse(24'h800000, 1'b0, 1'b0);
        tag = "R4"; wr(cw(8'h11, 1'b0, 1'b1, 1'b0, 1'b0));
        tag = "R9"; pulse(24'h000020, 1'b0, 1'b0);
        tag = "R11"; repeat (2) @(negedge clk);

        tag = "R7"; wr(cw(8'h77, 1'b0, 1'b0, 1'b1, 1'b0));
        tag = "R7"; pulse(24'h000001, 1'b0, 1'b0);
        tag = "R9"; pulse('0, 1'b1, 1'b0);

        tag = "R2"; wr(cw(8'hE1, 1'b1, 1'b1, 1'b1, 1'b1));
        tag = "R9"; pulse('0, 1'b1, 1'b0);
        tag = "R2"; wr(cw(8'h12, 1'b1, 1'b1, 1'b0, 1'b1));
        tag = "R6"; pulse('0, 1'b1, 1'b0);
        tag = "R10"; repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule